// File: doc/BRIEF.md
# Indirect PCI configuration access decoder

This block watches a host I/O port bus and implements the two-port indirect scheme for reaching PCI configuration space. One DWORD port holds a 32-bit pointer register that names a bus, device, function and DWORD offset. The DWORD port right after it is a data window. A read or write through that window becomes a configuration cycle aimed at the pointed-to location. Only a complete four-byte access reaches the pointer register. Narrower accesses to that port, and every access to any other port, are handed on unchanged as ordinary I/O.

When the pointer's enable bit is set, a data-window access is decoded into a configuration request. On bus zero, low device numbers go to the local configuration register file and the other device numbers go to the downstream port. A non-zero bus that equals the programmed downstream bus number also goes downstream. Any other non-zero bus ends as a master abort, so reads return all ones and writes are discarded. Only one access is in progress at a time. The I/O bus is held off until the target answers, and completion is signalled by a one-cycle ready pulse that carries the read data.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the pointer register reads as zero, `io_ready` is low, and none of `loc_req`, `dn_req` or `pt_req` is asserted.
- R2: A write with all four byte enables (`io_be` = 4'b1111) to DWORD port 0x33E (byte port 0xCF8) loads the pointer register. Bits 30:24 and 1:0 ignore the write and read back as zero. A full-DWORD read of the same port returns the register.
- R3: An access to DWORD port 0x33E with any byte-enable pattern other than 4'b1111 leaves the pointer register unchanged. It goes out on the pass-through port with the same write flag, DWORD address, byte enables and write data.
- R4: An access to DWORD port 0x33F (byte port 0xCFC) while pointer bit 31 is clear is passed through as ordinary I/O.
- R5: With bit 31 set, bus field (bits 23:16) zero and device field (bits 15:11) below 8, a data-window access raises `loc_req`. The request carries the function (bits 10:8) and offset (bits 7:2) fields together with the access's byte enables, write flag and write data, and a read returns `loc_rdata`.
- R6: With bit 31 set, bus zero and device 8 or above, a data-window access raises `dn_req` and a read returns `dn_rdata`.
- R7: With bit 31 set and a non-zero bus equal to `sec_bus`, a data-window access raises `dn_req`, and `cfg_bus` carries that bus number.
- R8: With bit 31 set and a non-zero bus other than `sec_bus`, a data-window read completes with 0xFFFFFFFF, and no access raises any target request.
- R9: An access to any DWORD port other than 0x33E and 0x33F is passed through unchanged and returns `pt_rdata`.
- R10: At most one of `loc_req`, `dn_req` and `pt_req` is high at a time. A request and its fields stay stable until the matching acknowledge arrives.
- R11: Every accepted access completes with `io_ready` high for exactly one cycle, which is the cycle after the target acknowledge or, for the pointer register and aborts, the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_bus | input | 8 | Bus number reached through the downstream port |
| io_req | input | 1 | I/O access present; held until `io_ready` |
| io_write | input | 1 | 1 = write, 0 = read |
| io_dwaddr | input | 14 | I/O DWORD address (byte address bits 15:2) |
| io_be | input | 4 | Byte enables of the I/O access |
| io_wdata | input | 32 | I/O write data |
| io_ready | output | 1 | One-cycle completion strobe |
| io_rdata | output | 32 | Read data, valid with `io_ready` |
| loc_req | output | 1 | Configuration request to the local register file |
| dn_req | output | 1 | Configuration request to the downstream port |
| cfg_bus | output | 8 | Request bus number |
| cfg_dev | output | 5 | Request device number |
| cfg_func | output | 3 | Request function number |
| cfg_off | output | 6 | Request DWORD offset |
| cfg_be | output | 4 | Request byte enables |
| cfg_write | output | 1 | Request write flag |
| cfg_wdata | output | 32 | Request write data |
| loc_ack | input | 1 | Local register file response strobe |
| loc_rdata | input | 32 | Local register file read data |
| dn_ack | input | 1 | Downstream response strobe |
| dn_rdata | input | 32 | Downstream read data |
| pt_req | output | 1 | Ordinary I/O pass-through request |
| pt_write | output | 1 | Pass-through write flag |
| pt_dwaddr | output | 14 | Pass-through DWORD address |
| pt_be | output | 4 | Pass-through byte enables |
| pt_wdata | output | 32 | Pass-through write data |
| pt_ack | input | 1 | Pass-through response strobe |
| pt_rdata | input | 32 | Pass-through read data |

## Verification
The assertions assume a well-behaved requester and well-behaved targets. The requester keeps `io_req` and its fields steady until `io_ready`, and each target pulses its acknowledge once, only while its own request is high. The bench honours these assumptions. It changes I/O inputs only at falling edges, drops the access on the falling edge where it sees `io_ready`, and runs each target responder as a process that waits a fixed number of cycles after the request and then acknowledges for exactly one cycle. `sec_bus` is changed only while no access is open.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    localparam int IO_AW  = 14;
    localparam int DW     = 32;
    localparam int BEW    = DW / 8;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int OFF_W  = 6;

    localparam int EN_BIT  = 31;
    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int FN_LSB  = 8;
    localparam int OFF_LSB = 2;

    // writable bits of the pointer register: enable and bus..offset
    localparam logic [DW-1:0] PTR_RW_MASK = 32'h80FF_FFFC;

    typedef enum logic [2:0] {
        RT_PTR_WR,
        RT_PTR_RD,
        RT_LOCAL,
        RT_DOWN,
        RT_ABORT,
        RT_PASS
    } route_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_LOC,
        ST_WAIT_DN,
        ST_WAIT_PT,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  func;
        logic [OFF_W-1:0] off;
        logic [BEW-1:0]   be;
        logic             write;
        logic [DW-1:0]    wdata;
    } cfg_req_t;

    typedef struct packed {
        logic             write;
        logic [IO_AW-1:0] dwaddr;
        logic [BEW-1:0]   be;
        logic [DW-1:0]    wdata;
    } io_req_t;

    function automatic logic [DW-1:0] ptr_sanitize(input logic [DW-1:0] v);
        return v & PTR_RW_MASK;
    endfunction

endpackage

// File: rtl/cfgdec_ptr_reg.sv
module cfgdec_ptr_reg
    import cfgdec_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] q
);

    logic [DW-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (wr_en) begin
            q_r <= ptr_sanitize(wr_data);
        end
    end

    assign q = q_r;

    // pointer only moves on a full-DWORD write strobe (R3)
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q_r));

endmodule

// File: rtl/cfgdec_router.sv
module cfgdec_router
    import cfgdec_pkg::*;
#(
    parameter logic [IO_AW-1:0] PTR_PORT   = 14'h33E,
    parameter logic [IO_AW-1:0] DATA_PORT  = 14'h33F,
    parameter int               LOCAL_DEVS = 8
) (
    input  io_req_t          io_in,
    input  logic [DW-1:0]    ptr_q,
    input  logic [BUS_W-1:0] sec_bus,
    output route_e           route,
    output cfg_req_t         cfg_out
);

    logic             en;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic             full_dw;

    assign en      = ptr_q[EN_BIT];
    assign bus     = ptr_q[BUS_LSB +: BUS_W];
    assign dev     = ptr_q[DEV_LSB +: DEV_W];
    assign full_dw = (io_in.be == {BEW{1'b1}});

    always_comb begin
        cfg_out.bus   = bus;
        cfg_out.dev   = dev;
        cfg_out.func  = ptr_q[FN_LSB +: FN_W];
        cfg_out.off   = ptr_q[OFF_LSB +: OFF_W];
        cfg_out.be    = io_in.be;
        cfg_out.write = io_in.write;
        cfg_out.wdata = io_in.wdata;
    end

    always_comb begin
        route = RT_PASS;
        if (io_in.dwaddr == PTR_PORT && full_dw) begin
            route = io_in.write ? RT_PTR_WR : RT_PTR_RD;
        end else if (io_in.dwaddr == DATA_PORT && en) begin
            if (bus == '0) begin
                route = (int'(dev) < LOCAL_DEVS) ? RT_LOCAL : RT_DOWN;
            end else if (bus == sec_bus) begin
                route = RT_DOWN;
            end else begin
                route = RT_ABORT;
            end
        end
    end

endmodule

// File: rtl/cfgdec_seq.sv
module cfgdec_seq
    import cfgdec_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          io_req,
    input  io_req_t       io_in,
    input  route_e        route,
    input  cfg_req_t      cfg_in,
    input  logic [DW-1:0] ptr_q,
    input  logic          loc_ack,
    input  logic [DW-1:0] loc_rdata,
    input  logic          dn_ack,
    input  logic [DW-1:0] dn_rdata,
    input  logic          pt_ack,
    input  logic [DW-1:0] pt_rdata,
    output logic          ptr_wr_en,
    output logic          io_ready,
    output logic [DW-1:0] io_rdata,
    output logic          loc_req,
    output logic          dn_req,
    output logic          pt_req,
    output cfg_req_t      cfg_q,
    output io_req_t       pt_q
);

    state_e        state;
    logic [DW-1:0] rdata_q;
    logic          loc_q, dn_q, pt_v;
    logic          accept;

    assign accept    = (state == ST_IDLE) && io_req;
    assign ptr_wr_en = accept && (route == RT_PTR_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rdata_q <= '0;
            loc_q   <= 1'b0;
            dn_q    <= 1'b0;
            pt_v    <= 1'b0;
            cfg_q   <= '0;
            pt_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (io_req) begin
                        case (route)
                            RT_PTR_WR: begin
                                rdata_q <= '0;
                                state   <= ST_RESP;
                            end
                            RT_PTR_RD: begin
                                rdata_q <= ptr_q;
                                state   <= ST_RESP;
                            end
                            RT_LOCAL: begin
                                cfg_q <= cfg_in;
                                loc_q <= 1'b1;
                                state <= ST_WAIT_LOC;
                            end
                            RT_DOWN: begin
                                cfg_q <= cfg_in;
                                dn_q  <= 1'b1;
                                state <= ST_WAIT_DN;
                            end
                            RT_ABORT: begin
                                rdata_q <= io_in.write ? '0 : '1;
                                state   <= ST_RESP;
                            end
                            default: begin
                                pt_q  <= io_in;
                                pt_v  <= 1'b1;
                                state <= ST_WAIT_PT;
                            end
                        endcase
                    end
                end
                ST_WAIT_LOC: begin
                    if (loc_ack) begin
                        loc_q   <= 1'b0;
                        rdata_q <= cfg_q.write ? '0 : loc_rdata;
                        state   <= ST_RESP;
                    end
                end
                ST_WAIT_DN: begin
                    if (dn_ack) begin
                        dn_q    <= 1'b0;
                        rdata_q <= cfg_q.write ? '0 : dn_rdata;
                        state   <= ST_RESP;
                    end
                end
                ST_WAIT_PT: begin
                    if (pt_ack) begin
                        pt_v    <= 1'b0;
                        rdata_q <= pt_q.write ? '0 : pt_rdata;
                        state   <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign io_ready = (state == ST_RESP);
    assign io_rdata = rdata_q;
    assign loc_req  = loc_q;
    assign dn_req   = dn_q;
    assign pt_req   = pt_v;

    assert_one_target_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({loc_q, dn_q, pt_v}));

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ((loc_q && !loc_ack) || (dn_q && !dn_ack)) |=> ((loc_q || dn_q) && $stable(cfg_q)));

    assert_pt_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (pt_v && !pt_ack) |=> (pt_v && $stable(pt_q)));

    assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        io_ready |=> !io_ready);

    assert_ack_completes_R11: assert property (@(posedge clk) disable iff (rst)
        ((loc_q && loc_ack) || (dn_q && dn_ack) || (pt_v && pt_ack)) |=> io_ready);

    assert_abort_ones_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && route == RT_ABORT && !io_in.write) |=> (io_ready && io_rdata == '1));

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import cfgdec_pkg::*;
#(
    parameter logic [IO_AW-1:0] PTR_PORT   = 14'h33E,
    parameter logic [IO_AW-1:0] DATA_PORT  = 14'h33F,
    parameter int               LOCAL_DEVS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic             io_req,
    input  logic             io_write,
    input  logic [IO_AW-1:0] io_dwaddr,
    input  logic [BEW-1:0]   io_be,
    input  logic [DW-1:0]    io_wdata,
    output logic             io_ready,
    output logic [DW-1:0]    io_rdata,
    output logic             loc_req,
    output logic             dn_req,
    output logic [BUS_W-1:0] cfg_bus,
    output logic [DEV_W-1:0] cfg_dev,
    output logic [FN_W-1:0]  cfg_func,
    output logic [OFF_W-1:0] cfg_off,
    output logic [BEW-1:0]   cfg_be,
    output logic             cfg_write,
    output logic [DW-1:0]    cfg_wdata,
    input  logic             loc_ack,
    input  logic [DW-1:0]    loc_rdata,
    input  logic             dn_ack,
    input  logic [DW-1:0]    dn_rdata,
    output logic             pt_req,
    output logic             pt_write,
    output logic [IO_AW-1:0] pt_dwaddr,
    output logic [BEW-1:0]   pt_be,
    output logic [DW-1:0]    pt_wdata,
    input  logic             pt_ack,
    input  logic [DW-1:0]    pt_rdata
);

    io_req_t       io_in;
    route_e        route;
    cfg_req_t      cfg_dec;
    cfg_req_t      cfg_q;
    io_req_t       pt_q;
    logic [DW-1:0] ptr_q;
    logic          ptr_wr_en;

    assign io_in = '{write: io_write, dwaddr: io_dwaddr, be: io_be, wdata: io_wdata};

    cfgdec_ptr_reg u_ptr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ptr_wr_en),
        .wr_data (io_wdata),
        .q       (ptr_q)
    );

    cfgdec_router #(
        .PTR_PORT   (PTR_PORT),
        .DATA_PORT  (DATA_PORT),
        .LOCAL_DEVS (LOCAL_DEVS)
    ) u_router (
        .io_in   (io_in),
        .ptr_q   (ptr_q),
        .sec_bus (sec_bus),
        .route   (route),
        .cfg_out (cfg_dec)
    );

    cfgdec_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .io_req    (io_req),
        .io_in     (io_in),
        .route     (route),
        .cfg_in    (cfg_dec),
        .ptr_q     (ptr_q),
        .loc_ack   (loc_ack),
        .loc_rdata (loc_rdata),
        .dn_ack    (dn_ack),
        .dn_rdata  (dn_rdata),
        .pt_ack    (pt_ack),
        .pt_rdata  (pt_rdata),
        .ptr_wr_en (ptr_wr_en),
        .io_ready  (io_ready),
        .io_rdata  (io_rdata),
        .loc_req   (loc_req),
        .dn_req    (dn_req),
        .pt_req    (pt_req),
        .cfg_q     (cfg_q),
        .pt_q      (pt_q)
    );

    assign cfg_bus   = cfg_q.bus;
    assign cfg_dev   = cfg_q.dev;
    assign cfg_func  = cfg_q.func;
    assign cfg_off   = cfg_q.off;
    assign cfg_be    = cfg_q.be;
    assign cfg_write = cfg_q.write;
    assign cfg_wdata = cfg_q.wdata;

    assign pt_write  = pt_q.write;
    assign pt_dwaddr = pt_q.dwaddr;
    assign pt_be     = pt_q.be;
    assign pt_wdata  = pt_q.wdata;

    // a configuration request only exists while the pointer enable is set (R5)
    assert_cfg_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
        (loc_req || dn_req) |-> ptr_q[EN_BIT]);

    // local requests only target low devices on bus zero (R5)
    assert_local_scope_R5: assert property (@(posedge clk) disable iff (rst)
        loc_req |-> (cfg_bus == '0 && int'(cfg_dev) < LOCAL_DEVS));

endmodule

// File: tb/cfg_port_decoder_tb_top.sv
module cfg_port_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RESP_DLY   = 2;
    localparam logic [13:0] PTR_P  = 14'h33E;
    localparam logic [13:0] DATA_P = 14'h33F;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  sec_bus;
    logic        io_req, io_write;
    logic [13:0] io_dwaddr;
    logic [3:0]  io_be;
    logic [31:0] io_wdata;
    logic        io_ready;
    logic [31:0] io_rdata;
    logic        loc_req, dn_req;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_off;
    logic [3:0]  cfg_be;
    logic        cfg_write;
    logic [31:0] cfg_wdata;
    logic        loc_ack = 1'b0, dn_ack = 1'b0, pt_ack = 1'b0;
    logic [31:0] loc_rdata = '0, dn_rdata = '0, pt_rdata = '0;
    logic        pt_req, pt_write;
    logic [13:0] pt_dwaddr;
    logic [3:0]  pt_be;
    logic [31:0] pt_wdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_port_decoder dut_i (
        .clk(clk), .rst(rst), .sec_bus(sec_bus),
        .io_req(io_req), .io_write(io_write), .io_dwaddr(io_dwaddr),
        .io_be(io_be), .io_wdata(io_wdata), .io_ready(io_ready), .io_rdata(io_rdata),
        .loc_req(loc_req), .dn_req(dn_req),
        .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_off(cfg_off),
        .cfg_be(cfg_be), .cfg_write(cfg_write), .cfg_wdata(cfg_wdata),
        .loc_ack(loc_ack), .loc_rdata(loc_rdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata),
        .pt_req(pt_req), .pt_write(pt_write), .pt_dwaddr(pt_dwaddr), .pt_be(pt_be),
        .pt_wdata(pt_wdata), .pt_ack(pt_ack), .pt_rdata(pt_rdata)
    );

    // target models: wait RESP_DLY cycles, record fields, acknowledge once
    logic [58:0] cfg_vec;
    logic [50:0] pt_vec;
    assign cfg_vec = {cfg_bus, cfg_dev, cfg_func, cfg_off, cfg_be, cfg_write, cfg_wdata};
    assign pt_vec  = {pt_write, pt_dwaddr, pt_be, pt_wdata};

    int loc_cnt = 0, dn_cnt = 0, pt_cnt = 0;
    int loc_w = 0, dn_w = 0, pt_w = 0;
    logic [58:0] loc_first, loc_last, dn_first, dn_last;
    logic [50:0] pt_first, pt_last;

    always @(negedge clk) begin
        if (loc_req && !loc_ack) begin
            if (loc_w == 0) loc_first <= cfg_vec;
            if (loc_w == RESP_DLY) begin
                loc_ack   <= 1'b1;
                loc_rdata <= 32'hA000_0000 | {18'd0, cfg_dev, cfg_func, cfg_off};
                loc_last  <= cfg_vec;
                loc_cnt   <= loc_cnt + 1;
                loc_w     <= 0;
            end else loc_w <= loc_w + 1;
        end else loc_ack <= 1'b0;
    end

    always @(negedge clk) begin
        if (dn_req && !dn_ack) begin
            if (dn_w == 0) dn_first <= cfg_vec;
            if (dn_w == RESP_DLY) begin
                dn_ack   <= 1'b1;
                dn_rdata <= 32'hB000_0000 | {8'd0, cfg_bus, cfg_dev, cfg_func, cfg_off};
                dn_last  <= cfg_vec;
                dn_cnt   <= dn_cnt + 1;
                dn_w     <= 0;
            end else dn_w <= dn_w + 1;
        end else dn_ack <= 1'b0;
    end

    always @(negedge clk) begin
        if (pt_req && !pt_ack) begin
            if (pt_w == 0) pt_first <= pt_vec;
            if (pt_w == RESP_DLY) begin
                pt_ack   <= 1'b1;
                pt_rdata <= 32'hC000_0000 | {18'd0, pt_dwaddr};
                pt_last  <= pt_vec;
                pt_cnt   <= pt_cnt + 1;
                pt_w     <= 0;
            end else pt_w <= pt_w + 1;
        end else pt_ack <= 1'b0;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic io_access(input bit wr, input logic [13:0] a, input logic [3:0] be,
                             input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        io_req = 1'b1; io_write = wr; io_dwaddr = a; io_be = be; io_wdata = wd;
        do @(negedge clk); while (!io_ready);
        rd = io_rdata;
        io_req = 1'b0;
        @(negedge clk);
        check(io_ready == 1'b0, "R11 single-cycle ready", 64'(io_ready), 64'd0);
    endtask

    task automatic set_ptr(input logic [31:0] v);
        logic [31:0] rd;
        io_access(1'b1, PTR_P, 4'hF, v, rd);
    endtask

    task automatic t_reset;
        logic [31:0] rd;
        check(!io_ready && !loc_req && !dn_req && !pt_req, "R1 idle outputs",
              64'({io_ready, loc_req, dn_req, pt_req}), 64'd0);
        io_access(1'b0, PTR_P, 4'hF, '0, rd);
        check(rd == 32'd0, "R1 pointer reset", 64'(rd), 64'd0);
    endtask

    task automatic t_ptr_write;
        logic [31:0] rd;
        set_ptr(32'hFFFF_FFFF);
        io_access(1'b0, PTR_P, 4'hF, '0, rd);
        check(rd == 32'h80FF_FFFC, "R2 reserved bits read zero", 64'(rd), 64'h80FF_FFFC);
        set_ptr(32'h8012_3456);
        io_access(1'b0, PTR_P, 4'hF, '0, rd);
        check(rd == 32'h8012_3454, "R2 pointer readback", 64'(rd), 64'h8012_3454);
    endtask

    task automatic t_partial_ptr;
        logic [31:0] rd;
        int c0;
        set_ptr(32'h0000_1234);
        c0 = pt_cnt;
        io_access(1'b1, PTR_P, 4'b0011, 32'hDEAD_BEEF, rd);
        check(pt_cnt == c0 + 1, "R3 narrow write passed through", 64'(pt_cnt), 64'(c0 + 1));
        check(pt_last == {1'b1, PTR_P, 4'b0011, 32'hDEAD_BEEF}, "R3 pass-through fields",
              64'(pt_last), 64'({1'b1, PTR_P, 4'b0011, 32'hDEAD_BEEF}));
        io_access(1'b0, PTR_P, 4'b1000, '0, rd);
        check(rd == (32'hC000_0000 | 32'(PTR_P)), "R3 narrow read returns I/O data",
              64'(rd), 64'(32'hC000_0000 | 32'(PTR_P)));
        io_access(1'b0, PTR_P, 4'hF, '0, rd);
        check(rd == 32'h0000_1234, "R3 pointer untouched", 64'(rd), 64'h1234);
    endtask

    task automatic t_data_disabled;
        logic [31:0] rd;
        int c0, l0;
        set_ptr(32'h0000_1D44);
        c0 = pt_cnt; l0 = loc_cnt;
        io_access(1'b0, DATA_P, 4'hF, '0, rd);
        check(pt_cnt == c0 + 1 && loc_cnt == l0, "R4 disabled window is plain I/O",
              64'(pt_cnt - c0), 64'd1);
        check(rd == (32'hC000_0000 | 32'(DATA_P)), "R4 read data",
              64'(rd), 64'(32'hC000_0000 | 32'(DATA_P)));
    endtask

    task automatic t_local;
        logic [31:0] rd;
        int l0;
        set_ptr(32'h8000_1D44);           // bus 0, dev 3, fn 5, off 0x11
        l0 = loc_cnt;
        io_access(1'b0, DATA_P, 4'hF, '0, rd);
        check(loc_cnt == l0 + 1, "R5 local request", 64'(loc_cnt - l0), 64'd1);
        check(rd == 32'hA000_0751, "R5 local read data", 64'(rd), 64'hA000_0751);
        io_access(1'b1, DATA_P, 4'b0101, 32'h1234_5678, rd);
        check(loc_last == {8'd0, 5'd3, 3'd5, 6'h11, 4'b0101, 1'b1, 32'h1234_5678},
              "R5 local request fields", 64'(loc_last),
              64'({8'd0, 5'd3, 3'd5, 6'h11, 4'b0101, 1'b1, 32'h1234_5678}));
        check(loc_first == loc_last, "R10 request stable until ack", 64'(loc_first), 64'(loc_last));
    endtask

    task automatic t_down_bus0;
        logic [31:0] rd;
        int d0, l0;
        set_ptr(32'h8000_4A08);           // bus 0, dev 9, fn 2, off 2
        d0 = dn_cnt; l0 = loc_cnt;
        io_access(1'b0, DATA_P, 4'hF, '0, rd);
        check(dn_cnt == d0 + 1 && loc_cnt == l0, "R6 high device downstream",
              64'(dn_cnt - d0), 64'd1);
        check(rd == 32'hB000_1282, "R6 downstream read data", 64'(rd), 64'hB000_1282);
    endtask

    task automatic t_sec_bus;
        logic [31:0] rd;
        int d0;
        sec_bus = 8'd5;
        set_ptr(32'h8005_0004);           // bus 5, dev 0, fn 0, off 1
        d0 = dn_cnt;
        io_access(1'b1, DATA_P, 4'b1100, 32'hCAFE_0000, rd);
        check(dn_cnt == d0 + 1, "R7 secondary bus downstream", 64'(dn_cnt - d0), 64'd1);
        check(dn_last[58:51] == 8'd5, "R7 bus number carried", 64'(dn_last[58:51]), 64'd5);
        check(dn_first == dn_last, "R10 downstream request stable", 64'(dn_first), 64'(dn_last));
    endtask

    task automatic t_abort;
        logic [31:0] rd;
        int s0;
        sec_bus = 8'd5;
        set_ptr(32'h8007_0800);           // bus 7: unknown
        s0 = loc_cnt + dn_cnt + pt_cnt;
        io_access(1'b0, DATA_P, 4'hF, '0, rd);
        check(rd == 32'hFFFF_FFFF, "R8 abort read all ones", 64'(rd), 64'hFFFF_FFFF);
        io_access(1'b1, DATA_P, 4'hF, 32'h5555_AAAA, rd);
        check(loc_cnt + dn_cnt + pt_cnt == s0, "R8 abort raises no request",
              64'(loc_cnt + dn_cnt + pt_cnt - s0), 64'd0);
    endtask

    task automatic t_other_port;
        logic [31:0] rd;
        int c0;
        c0 = pt_cnt;
        io_access(1'b0, 14'h0100, 4'hF, '0, rd);
        check(pt_cnt == c0 + 1, "R9 other port passed through", 64'(pt_cnt - c0), 64'd1);
        check(rd == 32'hC000_0100, "R9 other port read data", 64'(rd), 64'hC000_0100);
        io_access(1'b1, 14'h0101, 4'b0001, 32'h0000_00AB, rd);
        check(pt_last == {1'b1, 14'h0101, 4'b0001, 32'h0000_00AB}, "R9 write fields",
              64'(pt_last), 64'({1'b1, 14'h0101, 4'b0001, 32'h0000_00AB}));
        check(pt_first == pt_last, "R10 pass-through stable", 64'(pt_first), 64'(pt_last));
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; io_req = 1'b0; io_write = 1'b0; io_dwaddr = '0;
        io_be = '0; io_wdata = '0; sec_bus = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ptr_write();
        t_partial_ptr();
        t_data_disabled();
        t_local();
        t_down_bus0();
        t_sec_bus();
        t_abort();
        t_other_port();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule